// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers every reason a small microcontroller may need to restart and turns them into a single system reset. Eight requests feed it. Two come from the supply: a power-on indication and a power-fail fault. The others are the external reset pad, a conversion-start strobe, a comparator output, a software request from the core, a one-shot missing-clock pulse and a watchdog expiry. The strobe and the comparator count only while their own enable bits are set.

Every asynchronous request is synchronized and then merged as a wired-OR. While the supply is settling, the block pulls the external active-low reset pad low itself, and it ignores that pad while doing so. It holds the core in reset until a parameterised supply timeout has run out and the clock source reports stable. When it releases the core, it forces the watchdog on at its longest interval. A cause register keeps a record of which sources started the most recent reset.

Top module: `sysrst_hub`

## Requirements
- R1: Any enabled request, once synchronized (two clock edges for asynchronous inputs, none for the software request), asserts `sys_rst_o` at the next clock edge. The reset stays asserted while any request is active.
- R2: The conversion strobe causes no reset and sets no cause bit while `cnv_rst_en_i` is low. The comparator behaves the same way with `cmp_rst_en_i`.
- R3: `rst_pad_oe_o` (1 = pad driven low) is high throughout power-on. It stays high until `SUPPLY_TMO` cycles after the synchronized power-fail input falls. After power-on release it stays high for exactly `SUPPLY_TMO` edges.
- R4: If the power-fail input is reasserted, the supply timeout restarts from zero.
- R5: `sys_rst_o` is released only after the synchronized `clk_stable_i` is high. It is released at the third edge after `clk_stable_i` rises when nothing else holds it.
- R6: On release, `wdt_en_o`=1 and `wdt_sel_o` is all ones. After release, a `wdt_wr_i` write loads the enable and selection at the next edge. Writes made while in reset are ignored.
- R7: `cause_o` bit map: 0 power-on, 1 power-fail, 2 pad, 3 conversion strobe, 4 comparator, 5 software, 6 missing clock, 7 watchdog. When a new reset starts, the register is cleared and loaded with the active requests. Requests that arrive during the same reset are OR-ed in. The value is kept after release.
- R8: A missing-clock pulse of a single clock period produces a full reset, with cause 0x40.
- R9: The pad input is ignored while the block drives the pad and for two cycles after it stops. A supply reset therefore neither records the pad cause nor locks itself in reset.
- R10: `por_i` asserts `sys_rst_o` and `rst_pad_oe_o` asynchronously. It also sets `cause_o` to 0x01 and the watchdog defaults without a clock edge.
- R11: An external low on the pad produces a reset with cause 0x04 and does not make the block drive the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| pfail_i | input | 1 | Supply power-fail fault, active high |
| rst_pad_in_n | input | 1 | Level seen at the external reset pad, active low |
| rst_pad_oe_o | output | 1 | Drive the external reset pad low when 1 |
| cnv_strobe_i | input | 1 | External conversion-start strobe |
| cnv_rst_en_i | input | 1 | Allows the conversion strobe to reset |
| cmp_out_i | input | 1 | Comparator output |
| cmp_rst_en_i | input | 1 | Allows the comparator to reset |
| sw_rst_i | input | 1 | Software reset request, synchronous to clk |
| mclk_miss_i | input | 1 | Missing-clock one-shot pulse |
| wdt_exp_i | input | 1 | Watchdog expiry |
| clk_stable_i | input | 1 | System clock source reports stable |
| wdt_wr_i | input | 1 | Software write strobe for watchdog settings |
| wdt_en_i | input | 1 | Watchdog enable value to write |
| wdt_sel_i | input | WDT_SEL_W | Watchdog interval value to write |
| sys_rst_o | output | 1 | System reset to the core, active high |
| wdt_en_o | output | 1 | Watchdog enable |
| wdt_sel_o | output | WDT_SEL_W | Watchdog interval selection |
| cause_o | output | 8 | Latched reset cause |

## Verification
The hardest case is the supply reset's loop through the pad. The block's own low drive comes back on the pad input and must never count as a pad cause or keep the reset stuck. To reproduce this, the bench models the pad as a wired-AND of the block's drive and an external source. It then checks the cause value and the exact release cycle after both a power-on and a power-fail. The second hard case is a timeout restarting partway through, which the bench reaches by briefly reasserting power-fail in the middle of the count. Clock-stable gating needs the clock flag pulled low before a short software request, so that the reset outlives its source.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int NSRC     = 8;
  localparam int SRC_POR  = 0;
  localparam int SRC_PFL  = 1;
  localparam int SRC_PAD  = 2;
  localparam int SRC_CNV  = 3;
  localparam int SRC_CMP  = 4;
  localparam int SRC_SW   = 5;
  localparam int SRC_MCLK = 6;
  localparam int SRC_WDT  = 7;

  typedef logic [NSRC-1:0] cause_t;

  // New-reset load versus same-reset accumulate
  function automatic cause_t cause_next(input cause_t cur, input cause_t req,
                                        input logic in_reset);
    if (!in_reset && (|req)) return req;
    if (in_reset)            return cur | req;
    return cur;
  endfunction
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/sysrst_supply_timer.sv
module sysrst_supply_timer #(
  parameter int SUPPLY_TMO = 4096
) (
  input  logic clk,
  input  logic por_i,
  input  logic fault_s,
  output logic busy_o
);
  localparam int CW = $clog2(SUPPLY_TMO + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SUPPLY_TMO);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == LIMIT) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)        cnt <= '0;
    else if (fault_s) cnt <= '0;
    else              cnt <= sat_inc(cnt);
  end

  assign busy_o = (cnt != LIMIT);

  assert_fault_restarts_R4: assert property (@(posedge clk) disable iff (por_i)
    fault_s |=> (cnt == '0));
  assert_busy_after_fault_R3: assert property (@(posedge clk) disable iff (por_i)
    fault_s |=> busy_o);
  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (por_i)
    cnt <= LIMIT);
endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
  import sysrst_pkg::*;
(
  input  logic   clk,
  input  logic   por_i,
  input  logic   in_reset_i,
  input  cause_t req_i,
  output cause_t cause_o
);
  localparam cause_t POR_CAUSE = cause_t'(1) << SRC_POR;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) cause_o <= POR_CAUSE;
    else       cause_o <= cause_next(cause_o, req_i, in_reset_i);
  end

  assert_cause_keeps_R7: assert property (@(posedge clk) disable iff (por_i)
    (in_reset_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

// File: rtl/sysrst_wdt_default.sv
module sysrst_wdt_default #(
  parameter int WDT_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 por_i,
  input  logic                 in_reset_i,
  input  logic                 wr_i,
  input  logic                 en_i,
  input  logic [WDT_SEL_W-1:0] sel_i,
  output logic                 en_o,
  output logic [WDT_SEL_W-1:0] sel_o
);
  localparam logic [WDT_SEL_W-1:0] SEL_LONGEST = '1;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      en_o  <= 1'b1;
      sel_o <= SEL_LONGEST;
    end else if (in_reset_i) begin
      en_o  <= 1'b1;
      sel_o <= SEL_LONGEST;
    end else if (wr_i) begin
      en_o  <= en_i;
      sel_o <= sel_i;
    end
  end

  assert_release_defaults_R6: assert property (@(posedge clk) disable iff (por_i)
    $fell(in_reset_i) |-> (en_o && (sel_o == SEL_LONGEST)));
  assert_write_blocked_R6: assert property (@(posedge clk) disable iff (por_i)
    (in_reset_i && $past(in_reset_i)) |-> (en_o && (sel_o == SEL_LONGEST)));
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
  import sysrst_pkg::*;
#(
  parameter int SUPPLY_TMO = 4096,
  parameter int WDT_SEL_W  = 3
) (
  input  logic                 clk,
  input  logic                 por_i,
  input  logic                 pfail_i,
  input  logic                 rst_pad_in_n,
  output logic                 rst_pad_oe_o,
  input  logic                 cnv_strobe_i,
  input  logic                 cnv_rst_en_i,
  input  logic                 cmp_out_i,
  input  logic                 cmp_rst_en_i,
  input  logic                 sw_rst_i,
  input  logic                 mclk_miss_i,
  input  logic                 wdt_exp_i,
  input  logic                 clk_stable_i,
  input  logic                 wdt_wr_i,
  input  logic                 wdt_en_i,
  input  logic [WDT_SEL_W-1:0] wdt_sel_i,
  output logic                 sys_rst_o,
  output logic                 wdt_en_o,
  output logic [WDT_SEL_W-1:0] wdt_sel_o,
  output logic [NSRC-1:0]      cause_o
);
  localparam int SW_N = 7;
  localparam logic [SW_N-1:0] SYNC_IDLE = 7'b0000010;

  logic [SW_N-1:0] raw_in, synced;
  logic pfail_s, pad_s_n, cnv_s, cmp_s, mclk_s, wdt_s, clk_ok_s;
  logic supply_busy, pad_mask, pad_req, drv_d1, drv_d2, in_reset_q;
  cause_t req_vec, cause_q;

  assign raw_in = {clk_stable_i, wdt_exp_i, mclk_miss_i, cmp_out_i,
                   cnv_strobe_i, rst_pad_in_n, pfail_i};

  sysrst_sync #(.W(SW_N), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk (clk), .arst(por_i), .d_i(raw_in), .q_o(synced)
  );

  assign {clk_ok_s, wdt_s, mclk_s, cmp_s, cnv_s, pad_s_n, pfail_s} = synced;

  sysrst_supply_timer #(.SUPPLY_TMO(SUPPLY_TMO)) u_timer (
    .clk(clk), .por_i(por_i), .fault_s(pfail_s), .busy_o(supply_busy)
  );

  assign rst_pad_oe_o = supply_busy;

  // Drive history covers the synchronizer lag on the pad input
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      drv_d1 <= 1'b1;
      drv_d2 <= 1'b1;
    end else begin
      drv_d1 <= rst_pad_oe_o;
      drv_d2 <= drv_d1;
    end
  end

  assign pad_mask = rst_pad_oe_o | drv_d1 | drv_d2;
  assign pad_req  = ~pad_s_n & ~pad_mask;

  always_comb begin
    req_vec           = '0;
    req_vec[SRC_PFL]  = pfail_s;
    req_vec[SRC_PAD]  = pad_req;
    req_vec[SRC_CNV]  = cnv_s & cnv_rst_en_i;
    req_vec[SRC_CMP]  = cmp_s & cmp_rst_en_i;
    req_vec[SRC_SW]   = sw_rst_i;
    req_vec[SRC_MCLK] = mclk_s;
    req_vec[SRC_WDT]  = wdt_s;
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                        in_reset_q <= 1'b1;
    else if ((|req_vec) || supply_busy) in_reset_q <= 1'b1;
    else if (clk_ok_s)                in_reset_q <= 1'b0;
  end

  assign sys_rst_o = in_reset_q;

  sysrst_cause u_cause (
    .clk(clk), .por_i(por_i), .in_reset_i(in_reset_q),
    .req_i(req_vec), .cause_o(cause_q)
  );
  assign cause_o = cause_q;

  sysrst_wdt_default #(.WDT_SEL_W(WDT_SEL_W)) u_wdt (
    .clk(clk), .por_i(por_i), .in_reset_i(in_reset_q),
    .wr_i(wdt_wr_i), .en_i(wdt_en_i), .sel_i(wdt_sel_i),
    .en_o(wdt_en_o), .sel_o(wdt_sel_o)
  );

  assert_request_resets_R1: assert property (@(posedge clk) disable iff (por_i)
    (|req_vec) |=> sys_rst_o);
  assert_cnv_gated_R2: assert property (@(posedge clk) disable iff (por_i)
    $rose(cause_o[SRC_CNV]) |-> $past(cnv_rst_en_i));
  assert_cmp_gated_R2: assert property (@(posedge clk) disable iff (por_i)
    $rose(cause_o[SRC_CMP]) |-> $past(cmp_rst_en_i));
  assert_release_clock_ok_R5: assert property (@(posedge clk) disable iff (por_i)
    $fell(sys_rst_o) |-> $past(clk_ok_s));
  assert_release_no_supply_R3: assert property (@(posedge clk) disable iff (por_i)
    $fell(sys_rst_o) |-> !$past(rst_pad_oe_o));
  assert_reload_subset_R7: assert property (@(posedge clk) disable iff (por_i)
    $rose(sys_rst_o) |-> ((cause_o & ~$past(req_vec)) == '0));
  assert_pad_self_masked_R9: assert property (@(posedge clk) disable iff (por_i)
    rst_pad_oe_o |=> !cause_o[SRC_PAD] || $past(cause_o[SRC_PAD]));
endmodule

// File: tb/sysrst_hub_test.sv
module sysrst_hub_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam int SW = 3;
  localparam int NV = 8;
  // entry: {cnv_en, cmp_en, wdt, mclk, sw, cmp, cnv, pad_low} , {rst, cause}
  localparam logic [16:0] VEC [NV] = '{
    {8'b0010_0000, 1'b1, 8'h80},
    {8'b0000_0010, 1'b0, 8'h80},
    {8'b1000_0010, 1'b1, 8'h08},
    {8'b0000_0100, 1'b0, 8'h08},
    {8'b0100_0100, 1'b1, 8'h10},
    {8'b0000_0001, 1'b1, 8'h04},
    {8'b0010_1000, 1'b1, 8'hA0},
    {8'b1101_0110, 1'b1, 8'h58}
  };

  logic clk = 0;
  logic por = 1, pfail = 0, ext_pad_n = 1, cnv = 0, cnv_en = 0, cmp = 0, cmp_en = 0;
  logic sw = 0, mclk = 0, wdt = 0, clk_st = 1, wwr = 0, wen = 0;
  logic [SW-1:0] wsel = '0;
  logic pad_n, pad_oe, sys_rst, wdt_en_o;
  logic [SW-1:0] wdt_sel_o;
  logic [7:0] cause;
  int checks = 0, errors = 0;
  bit done = 0;

  assign pad_n = ext_pad_n & ~pad_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysrst_hub #(.SUPPLY_TMO(TMO), .WDT_SEL_W(SW)) uut (
    .clk(clk), .por_i(por), .pfail_i(pfail), .rst_pad_in_n(pad_n),
    .rst_pad_oe_o(pad_oe), .cnv_strobe_i(cnv), .cnv_rst_en_i(cnv_en),
    .cmp_out_i(cmp), .cmp_rst_en_i(cmp_en), .sw_rst_i(sw), .mclk_miss_i(mclk),
    .wdt_exp_i(wdt), .clk_stable_i(clk_st), .wdt_wr_i(wwr), .wdt_en_i(wen),
    .wdt_sel_i(wsel), .sys_rst_o(sys_rst), .wdt_en_o(wdt_en_o),
    .wdt_sel_o(wdt_sel_o), .cause_o(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    // R10: asynchronous reset state
    chk("R10 sys_rst", sys_rst, 1);
    chk("R10 pad_oe", pad_oe, 1);
    chk("R10 cause", cause, 8'h01);
    chk("R10 wdt", {wdt_en_o, wdt_sel_o}, {1'b1, 3'b111});
    @(negedge clk); por = 0;
    edges(TMO - 1);
    chk("R3 pad held", pad_oe, 1);
    chk("R3 rst held", sys_rst, 1);
    edges(1);
    chk("R3 pad drops", pad_oe, 0);
    edges(1);
    chk("R9 release after POR", sys_rst, 0);
    chk("R7 por cause kept", cause, 8'h01);
    chk("R6 wdt default", {wdt_en_o, wdt_sel_o}, {1'b1, 3'b111});

    // R1/R2/R7/R11 table walk
    for (int i = 0; i < NV; i++) begin
      {cnv_en, cmp_en, wdt, mclk, sw, cmp, cnv} = VEC[i][16:10];
      ext_pad_n = ~VEC[i][9];
      edges(3);
      chk($sformatf("R1 R2 vec%0d rst", i), sys_rst, VEC[i][8]);
      chk($sformatf("R7 vec%0d cause", i), cause, VEC[i][7:0]);
      if (VEC[i][9]) chk("R11 no pad drive", pad_oe, 0);
      {cnv_en, cmp_en, wdt, mclk, sw, cmp, cnv} = '0;
      ext_pad_n = 1;
      edges(5);
      chk($sformatf("R1 vec%0d release", i), sys_rst, 0);
    end

    // R6 software write after release
    wwr = 1; wen = 0; wsel = 3'd2;
    edges(1);
    wwr = 0;
    chk("R6 write taken", {wdt_en_o, wdt_sel_o}, {1'b0, 3'd2});

    // R8 single-period missing-clock pulse
    mclk = 1; @(negedge clk); mclk = 0;
    edges(2);
    chk("R8 reset", sys_rst, 1);
    chk("R8 cause", cause, 8'h40);
    edges(1);
    chk("R8 release", sys_rst, 0);

    // R5 clock-stable gating, R6 write during reset ignored
    clk_st = 0; edges(3);
    sw = 1; @(negedge clk); sw = 0;
    edges(2);
    wwr = 1; wen = 0; wsel = 3'd1;
    edges(1); wwr = 0;
    chk("R6 write ignored", {wdt_en_o, wdt_sel_o}, {1'b1, 3'b111});
    edges(8);
    chk("R5 held", sys_rst, 1);
    chk("R7 sw cause", cause, 8'h20);
    clk_st = 1;
    edges(2);
    chk("R5 still held", sys_rst, 1);
    edges(1);
    chk("R5 released", sys_rst, 0);
    chk("R6 default on release", {wdt_en_o, wdt_sel_o}, {1'b1, 3'b111});

    // R3/R4/R9 power-fail with pad loop and restart
    pfail = 1;
    edges(3);
    chk("R3 pfail rst", sys_rst, 1);
    chk("R3 pfail pad", pad_oe, 1);
    edges(4);
    pfail = 0;
    edges(4);
    pfail = 1; edges(2); pfail = 0;
    edges(TMO + 1);
    chk("R4 pad still driven", pad_oe, 1);
    edges(1);
    chk("R4 pad drops", pad_oe, 0);
    chk("R4 rst held", sys_rst, 1);
    edges(1);
    chk("R9 released", sys_rst, 0);
    chk("R9 cause no pad", cause, 8'h02);
    edges(4);
    chk("R9 no relatch", sys_rst, 0);

    // R10 asynchronous assertion mid-cycle
    @(posedge clk); #(CLK_PERIOD/4);
    por = 1; #1;
    chk("R10 async rst", sys_rst, 1);
    chk("R10 async pad", pad_oe, 1);
    chk("R10 async cause", cause, 8'h01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule